// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a bank of independent external request lines and turns activity on each of them into interrupt and wakeup requests. Each line takes one input signal that has already been selected and synchronised to the block clock. The signal first passes through a deglitch filter. The filtered level is then compared against a per-line trigger condition: high level, low level, falling edge, rising edge or either edge. When the condition holds, the line's status flag is set.

Software can also set a line's status directly through a software trigger strobe, whatever the input is doing. It clears status flags by pulsing a write-one-to-clear vector. Each line has its own interrupt enable and its own wakeup enable. The interrupt output is a vector with one request per line. The wakeup output is a single request shared by all lines.

Top module: `ext_irq_lines`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `status`, `irq_req` and `wake_req` are all zero.
- R2: The deglitch filter on a line with length L (1..255) passes a new input level only after the input has held that level for L consecutive clock samples. A shorter pulse never reaches the trigger logic. L = 0 bypasses the filter and behaves like L = 1.
- R3: Trigger code 0 (high level) sets status on every cycle in which the filtered level is 1. A clear pulse has no lasting effect while that level persists.
- R4: Trigger code 1 (low level) sets status on every cycle in which the filtered level is 0. A clear pulse has no lasting effect while that level persists.
- R5: Trigger codes 2 (falling edge) and 3 (rising edge) set status on the matching transition of the filtered level. The flag then stays set until it is cleared.
- R6: Trigger code 4 (both edges) sets status on either transition of the filtered level.
- R7: Codes 5, 6 and 7 select no hardware trigger, so input activity never sets status on such a line. A one-cycle pulse on `sw_trig[i]` sets `status[i]` under any code and any input.
- R8: A pulse on `status_clr[i]` clears `status[i]` on the next edge. If a trigger or a software strobe arrives in the same cycle, the set wins.
- R9: `irq_req[i]` is high exactly when `status[i]` and `irq_en[i]` are both high. A masked line raises no interrupt request.
- R10: `wake_req` is high exactly when at least one line has both its status and its wakeup enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Synchronised source level per line |
| trig_mode | input | 3*NUM_LINES | Trigger code per line, line i in bits [3i+2:3i] |
| filt_len | input | FILT_W*NUM_LINES | Filter length per line, line i in bits [FILT_W*i +: FILT_W] |
| irq_en | input | NUM_LINES | Interrupt enable per line |
| wake_en | input | NUM_LINES | Wakeup enable per line |
| sw_trig | input | NUM_LINES | Software trigger strobe per line |
| status_clr | input | NUM_LINES | Write-one-to-clear strobe for status |
| status | output | NUM_LINES | Per-line status flags |
| irq_req | output | NUM_LINES | Per-line interrupt requests |
| wake_req | output | 1 | Combined wakeup request |

## Verification
Latency is counted in clock edges from the edge that samples a changed input.

With the filter bypassed, the filtered level updates on that first edge and the status flag on the following one, so a status change appears two edges after the input change. A filter of length L moves the filtered level on the L-th consecutive sample, and status follows one edge later. A software strobe or clear acts on status at the very edge that samples it. The interrupt and wakeup outputs follow status in the same cycle.

The bench's behavioural model advances on the same edges. All stimulus changes, and every comparison of outputs against the model, happen on falling edges, so each expected value is already settled when it is read.

// File: rtl/ext_irq_lines.sv
module ext_irq_lines #(
  parameter int NUM_LINES = 16,
  parameter int FILT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        line_in,
  input  logic [3*NUM_LINES-1:0]      trig_mode,
  input  logic [FILT_W*NUM_LINES-1:0] filt_len,
  input  logic [NUM_LINES-1:0]        irq_en,
  input  logic [NUM_LINES-1:0]        wake_en,
  input  logic [NUM_LINES-1:0]        sw_trig,
  input  logic [NUM_LINES-1:0]        status_clr,
  output logic [NUM_LINES-1:0]        status,
  output logic [NUM_LINES-1:0]        irq_req,
  output logic                        wake_req
);

  localparam logic [2:0] M_HIGH = 3'd0;
  localparam logic [2:0] M_LOW  = 3'd1;
  localparam logic [2:0] M_FALL = 3'd2;
  localparam logic [2:0] M_RISE = 3'd3;
  localparam logic [2:0] M_BOTH = 3'd4;

  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] lvl_d;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] hw_mode;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [2:0]        mode;
    logic [FILT_W-1:0] len;
    logic [FILT_W-1:0] run;
    logic              lvl_q;
    logic              lvl_dq;
    logic              cond;

    assign mode = trig_mode[3*i +: 3];
    assign len  = filt_len[FILT_W*i +: FILT_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q  <= 1'b0;
        lvl_dq <= 1'b0;
        run    <= '0;
      end else begin
        lvl_dq <= lvl_q;
        if (len == '0) begin
          lvl_q <= line_in[i];
          run   <= '0;
        end else if (line_in[i] != lvl_q) begin
          if (run == len - 1'b1) begin
            lvl_q <= line_in[i];
            run   <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          run <= '0;
        end
      end
    end

    always_comb begin
      case (mode)
        M_HIGH:  cond = lvl_q;
        M_LOW:   cond = !lvl_q;
        M_FALL:  cond = lvl_dq && !lvl_q;
        M_RISE:  cond = !lvl_dq && lvl_q;
        M_BOTH:  cond = lvl_dq != lvl_q;
        default: cond = 1'b0;
      endcase
    end

    assign lvl[i]     = lvl_q;
    assign lvl_d[i]   = lvl_dq;
    assign hit[i]     = cond;
    assign hw_mode[i] = mode <= M_BOTH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~status_clr) | hit | sw_trig;
  end

  assign irq_req  = status & irq_en;
  assign wake_req = |(status & wake_en);

  // R7: a software strobe is always reflected in status on the next cycle
  a_r7_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_trig) |=> ((status & $past(sw_trig)) == $past(sw_trig)));

  // R8: a flag only drops on a cycle that carried its clear strobe
  a_r8_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) & ~status & ~$past(status_clr)) == '0);

  // R2: the filtered level only ever moves to a value the input had
  a_r2_filter_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl ^ lvl_d) & (lvl ^ $past(line_in))) == '0);

  // R7: a flag on a line without a hardware trigger only rises by software
  a_r7_no_hw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(hw_mode) & ~$past(sw_trig)) == '0);

endmodule

// File: tb/ext_irq_lines_test.sv
`timescale 1ns/1ps
module ext_irq_lines_test;
  localparam int N  = 16;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    line_in = '0;
  logic [3*N-1:0]  trig_mode = {N{3'd7}};
  logic [FW*N-1:0] filt_len = '0;
  logic [N-1:0]    irq_en = '0, wake_en = '0, sw_trig = '0, status_clr = '0;
  logic [N-1:0]    status, irq_req;
  logic            wake_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_lvl[N], m_lvld[N], m_run[N], m_st[N];

  ext_irq_lines #(.NUM_LINES(N), .FILT_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .trig_mode(trig_mode),
    .filt_len(filt_len), .irq_en(irq_en), .wake_en(wake_en),
    .sw_trig(sw_trig), .status_clr(status_clr), .status(status),
    .irq_req(irq_req), .wake_req(wake_req));

  always #4 clk = ~clk;

  function automatic string tag_for(int mode);
    case (mode)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      int mode, len, ev;
      mode = trig_mode[3*i +: 3];
      len  = filt_len[FW*i +: FW];
      if (!rst_n) begin
        m_lvl[i] = 0; m_lvld[i] = 0; m_run[i] = 0; m_st[i] = 0;
      end else begin
        case (mode)
          0: ev = m_lvl[i];
          1: ev = !m_lvl[i];
          2: ev = m_lvld[i] && !m_lvl[i];
          3: ev = !m_lvld[i] && m_lvl[i];
          4: ev = m_lvld[i] != m_lvl[i];
          default: ev = 0;
        endcase
        m_st[i] = ((m_st[i] != 0 && !status_clr[i]) || ev != 0 || sw_trig[i]) ? 1 : 0;
        m_lvld[i] = m_lvl[i];
        if (len == 0) begin
          m_lvl[i] = line_in[i]; m_run[i] = 0;
        end else if (int'(line_in[i]) != m_lvl[i]) begin
          if (m_run[i] == len - 1) begin m_lvl[i] = line_in[i]; m_run[i] = 0; end
          else m_run[i]++;
        end else m_run[i] = 0;
      end
    end
  end

  // Compare every cycle on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int w;
      w = 0;
      for (int i = 0; i < N; i++) begin
        chk(tag_for(int'(trig_mode[3*i +: 3])), status[i], m_st[i]);
        chk("R9", irq_req[i], m_st[i] & irq_en[i]);
        if (m_st[i] != 0 && wake_en[i]) w = 1;
      end
      chk("R10", wake_req, w);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int i, int mode, int len);
    trig_mode[3*i +: 3] = mode[2:0];
    filt_len[FW*i +: FW] = len[FW-1:0];
  endtask

  task automatic pulse_clr(logic [N-1:0] v);
    status_clr = v; cyc(1); status_clr = '0;
  endtask

  task automatic pulse_sw(logic [N-1:0] v);
    sw_trig = v; cyc(1); sw_trig = '0;
  endtask

  initial begin
    cyc(3);
    // R1: outputs held at zero during reset
    chk("R1", status, 0); chk("R1", irq_req, 0); chk("R1", wake_req, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", status, 0);

    // R3: high level keeps status set through a clear
    set_mode(0, 0, 0); line_in[0] = 1'b1; cyc(3);
    chk("R3", status[0], 1);
    pulse_clr(16'h0001); cyc(1);
    chk("R3", status[0], 1);
    line_in[0] = 1'b0; cyc(3); pulse_clr(16'h0001); cyc(1);
    chk("R8", status[0], 0);

    // R4: low level
    set_mode(1, 1, 0); cyc(3);
    chk("R4", status[1], 1);
    line_in[1] = 1'b1; cyc(3); pulse_clr(16'h0002); cyc(1);
    chk("R4", status[1], 0);

    // R5: falling edge is sticky
    line_in[2] = 1'b1; set_mode(2, 2, 0); cyc(3); pulse_clr(16'h0004); cyc(1);
    chk("R5", status[2], 0);
    line_in[2] = 1'b0; cyc(3);
    chk("R5", status[2], 1);
    cyc(5);
    chk("R5", status[2], 1);
    pulse_clr(16'h0004); cyc(1);
    chk("R5", status[2], 0);

    // R6: both edges
    set_mode(4, 4, 0); cyc(2);
    line_in[4] = 1'b1; cyc(3);
    chk("R6", status[4], 1);
    pulse_clr(16'h0010); cyc(2);
    chk("R6", status[4], 0);
    line_in[4] = 1'b0; cyc(3);
    chk("R6", status[4], 1);

    // R2: filter length 4 on a rising-edge line
    set_mode(3, 3, 4); cyc(2);
    line_in[3] = 1'b1; cyc(3); line_in[3] = 1'b0; cyc(8);
    chk("R2", status[3], 0);
    line_in[3] = 1'b1; cyc(4); line_in[3] = 1'b0; cyc(8);
    chk("R2", status[3], 1);

    // R7: code without hardware trigger, then software strobe
    set_mode(5, 6, 0); line_in[5] = 1'b1; cyc(3); line_in[5] = 1'b0; cyc(3);
    chk("R7", status[5], 0);
    pulse_sw(16'h0020);
    chk("R7", status[5], 1);

    // R8: set wins over clear in the same cycle
    status_clr = 16'h0040; sw_trig = 16'h0040; cyc(1);
    status_clr = '0; sw_trig = '0;
    chk("R8", status[6], 1);

    // R9 / R10: masking
    irq_en = 16'h0020; cyc(1);
    chk("R9", irq_req[5], 1); chk("R9", irq_req[6], 0);
    wake_en = 16'h0040; cyc(1);
    chk("R10", wake_req, 1);
    pulse_clr(16'h0060); cyc(1);
    chk("R10", wake_req, 0);

    // Random phase, checked by the per-cycle model
    for (int i = 0; i < N; i++) set_mode(i, i % 8, (i % 4 == 0) ? 0 : (i % 4) * 2 - 1);
    for (int k = 0; k < 6000; k++) begin
      if (k % 1000 == 0) begin
        irq_en = N'($urandom); wake_en = N'($urandom);
        for (int i = 0; i < N; i++) set_mode(i, $urandom % 8, $urandom % 6);
      end
      if ($urandom % 3 == 0) line_in = line_in ^ N'($urandom & $urandom);
      sw_trig = ($urandom % 16 == 0) ? N'($urandom & $urandom) : '0;
      status_clr = ($urandom % 4 == 0) ? N'($urandom) : '0;
      cyc(1);
    end
    sw_trig = '0; status_clr = '0;
    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule